// File: doc/BRIEF.md
# Chunk Commit Order Arbiter

This block decides, for a group of processor cores that each run in atomic chunks, which core may commit its current chunk. It grants at most one commit per clock, so all commits across the machine fall into a single global sequence. That sequence is the only thing kept for deterministic replay. No per-access dependence between threads is ever logged.

A two-bit mode input selects the policy. In free recording (`2'b00`), a rotating priority picks among the cores that are asking, and the identity of each winner goes out on a log write port. In the two turn-based modes (`2'b01` for recording, `2'b11` for replaying), commits follow a fixed cyclic turn order with no log at all. A core whose turn has not come waits, even when nobody else is asking. In log replay (`2'b10`), the block pulls committer IDs from an external log through a valid/ready port. It then grants only the core named by the entry it holds. A stored ID that names no existing core is dropped, and a sticky error flag is raised.

The number of cores is a parameter from 2 to 16. Core IDs are `ceil(log2(N_CORES))` bits wide.

Top module: `commit_order_arbiter`

## Requirements
- R1: `gnt` has at most one bit set in any cycle. A grant appears one clock after the request it answers was sampled, and it goes only to a core whose `req` bit was high in that sampled cycle. A core whose `gnt` bit is high in the current cycle is not eligible in that same cycle, so `gnt` is always a one-cycle pulse.
- R2: In free mode (`mode` = `2'b00`), the eligible core found first when searching upward, with wrap, from a priority pointer wins. The pointer then moves to the winner's ID plus one, modulo `N_CORES`. After reset the pointer is 0.
- R3: In free mode, each grant is accompanied in the same cycle by `log_wr_valid` high and `log_wr_id` equal to the granted core's ID. There is exactly one log write per grant.
- R4: In the turn modes (`2'b01` and `2'b11`), only the core whose turn it is can be granted. Turns run 0, 1, ..., `N_CORES`-1 and then wrap. A turn passes only when that core is granted, so all other cores wait, including when they are the only ones requesting.
- R5: `log_wr_valid` is high only in the cycle after a decision made in free mode. `log_rd_ready` is high only while the mode has been `2'b10` for at least one clock and no log entry is held.
- R6: In log replay (`2'b10`), an entry accepted on a `log_rd_valid`/`log_rd_ready` handshake is held. Only the core it names can be granted, and the entry is released at that grant. The next handshake can happen in the cycle after the grant.
- R7: In log replay with no entry held and `log_rd_valid` low, no grant is given.
- R8: A log entry whose ID is `N_CORES` or above is dropped without a grant. `replay_bad_id` rises one clock after the handshake and stays high until reset.
- R9: In a cycle where `mode` differs from its value in the previous cycle, no grant is made. The priority or turn pointer returns to 0, and any held log entry is discarded.
- R10: During and after reset, `gnt`, `log_wr_valid`, `log_rd_ready` and `replay_bad_id` are all 0, and the mode register holds free mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 free record, 01 turn record, 10 log replay, 11 turn replay |
| req | input | N_CORES | Per-core commit request |
| gnt | output | N_CORES | Per-core one-cycle commit grant |
| log_wr_valid | output | 1 | A committer ID is written to the log this cycle |
| log_wr_id | output | ID_W | Committer ID being written |
| log_rd_valid | input | 1 | Log read port holds an entry |
| log_rd_id | input | ID_W | Committer ID of the offered entry |
| log_rd_ready | output | 1 | Arbiter accepts the offered entry this cycle |
| replay_bad_id | output | 1 | Sticky flag: an out-of-range ID was read in replay |

## Verification
Grants and log writes come from one register stage, so they are due one clock after the cycle whose `req`, `mode` and held entry decided them. The bench drives inputs on the falling edge and compares `gnt`, `log_wr_*` and `replay_bad_id` at the next falling edge against a behavioural model stepped with the same inputs. `log_rd_ready` is combinational from state and `mode`, so it is checked 1 ns after the inputs change, before the rising edge. A log entry is removed from the bench queue only after the edge that consumed it. The error flag from a bad entry is therefore expected in the cycle right after that edge.

// File: rtl/coa_pkg.sv
package coa_pkg;

    typedef enum logic [1:0] {
        MODE_FREE       = 2'b00,
        MODE_TURN_REC   = 2'b01,
        MODE_LOG_REPLAY = 2'b10,
        MODE_TURN_PLAY  = 2'b11
    } coa_mode_e;

endpackage

// File: rtl/coa_rotate_pick.sv
module coa_rotate_pick #(
    parameter int N_CORES = 6,
    parameter int ID_W    = 3
) (
    input  logic [N_CORES-1:0] elig,
    input  logic [ID_W-1:0]    start,
    output logic               found,
    output logic [ID_W-1:0]    win
);
    // Search downward so the last hit is the one nearest the start point.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = N_CORES - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(start) + k) % N_CORES;
            if (elig[idx]) begin
                found = 1'b1;
                win   = ID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/coa_ptr_inc.sv
module coa_ptr_inc #(
    parameter int N_CORES = 6,
    parameter int ID_W    = 3
) (
    input  logic [ID_W-1:0] cur,
    output logic [ID_W-1:0] nxt
);
    assign nxt = (cur == ID_W'(N_CORES - 1)) ? '0 : cur + 1'b1;
endmodule

// File: rtl/coa_id_decode.sv
module coa_id_decode #(
    parameter int N_CORES = 6,
    parameter int ID_W    = 3
) (
    input  logic [ID_W-1:0]    id,
    output logic [N_CORES-1:0] oh
);
    for (genvar g = 0; g < N_CORES; g++) begin : g_bit
        assign oh[g] = (id == ID_W'(g));
    end
endmodule

// File: rtl/commit_order_arbiter.sv
module commit_order_arbiter
    import coa_pkg::*;
#(
    parameter int N_CORES = 6,
    parameter int ID_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic [N_CORES-1:0] req,
    output logic [N_CORES-1:0] gnt,
    output logic               log_wr_valid,
    output logic [ID_W-1:0]    log_wr_id,
    input  logic               log_rd_valid,
    input  logic [ID_W-1:0]    log_rd_id,
    output logic               log_rd_ready,
    output logic               replay_bad_id
);
    localparam logic [ID_W:0] CORE_LIMIT = (ID_W + 1)'(N_CORES);

    typedef struct packed {
        coa_mode_e          mode;
        logic [ID_W-1:0]    ptr;
        logic               hold_v;
        logic [ID_W-1:0]    hold_id;
        logic [N_CORES-1:0] gnt;
        logic               wr_v;
        logic [ID_W-1:0]    wr_id;
        logic               err;
    } arb_state_t;

    arb_state_t s_q, s_d;

    logic [N_CORES-1:0] elig;
    logic               pick_found;
    logic [ID_W-1:0]    pick_win;
    logic [ID_W-1:0]    ptr_next;
    logic [ID_W-1:0]    win_next;
    logic [N_CORES-1:0] ptr_oh;
    logic [N_CORES-1:0] hold_oh;
    logic [N_CORES-1:0] win_oh;
    logic               mode_chg;
    logic               rd_ready;
    logic               rd_in_range;

    assign elig        = req & ~s_q.gnt;
    assign mode_chg    = (mode != s_q.mode);
    assign rd_in_range = ({1'b0, log_rd_id} < CORE_LIMIT);
    assign rd_ready    = (s_q.mode == MODE_LOG_REPLAY) && !mode_chg && !s_q.hold_v;

    coa_rotate_pick #(.N_CORES(N_CORES), .ID_W(ID_W)) u_pick (
        .elig  (elig),
        .start (s_q.ptr),
        .found (pick_found),
        .win   (pick_win)
    );

    coa_ptr_inc #(.N_CORES(N_CORES), .ID_W(ID_W)) u_inc_ptr (
        .cur (s_q.ptr),
        .nxt (ptr_next)
    );

    coa_ptr_inc #(.N_CORES(N_CORES), .ID_W(ID_W)) u_inc_win (
        .cur (pick_win),
        .nxt (win_next)
    );

    coa_id_decode #(.N_CORES(N_CORES), .ID_W(ID_W)) u_dec_ptr (
        .id (s_q.ptr),
        .oh (ptr_oh)
    );

    coa_id_decode #(.N_CORES(N_CORES), .ID_W(ID_W)) u_dec_hold (
        .id (s_q.hold_id),
        .oh (hold_oh)
    );

    coa_id_decode #(.N_CORES(N_CORES), .ID_W(ID_W)) u_dec_win (
        .id (pick_win),
        .oh (win_oh)
    );

    always_comb begin
        s_d       = s_q;
        s_d.gnt   = '0;
        s_d.wr_v  = 1'b0;
        s_d.wr_id = '0;
        if (mode_chg) begin
            s_d.mode   = coa_mode_e'(mode);
            s_d.ptr    = '0;
            s_d.hold_v = 1'b0;
        end else begin
            unique case (s_q.mode)
                MODE_FREE: begin
                    if (pick_found) begin
                        s_d.gnt   = win_oh;
                        s_d.wr_v  = 1'b1;
                        s_d.wr_id = pick_win;
                        s_d.ptr   = win_next;
                    end
                end
                MODE_TURN_REC, MODE_TURN_PLAY: begin
                    if (|(ptr_oh & elig)) begin
                        s_d.gnt = ptr_oh;
                        s_d.ptr = ptr_next;
                    end
                end
                MODE_LOG_REPLAY: begin
                    if (s_q.hold_v && |(hold_oh & elig)) begin
                        s_d.gnt    = hold_oh;
                        s_d.hold_v = 1'b0;
                    end else if (rd_ready && log_rd_valid) begin
                        if (rd_in_range) begin
                            s_d.hold_v  = 1'b1;
                            s_d.hold_id = log_rd_id;
                        end else begin
                            s_d.err = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.mode    <= MODE_FREE;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt           = s_q.gnt;
    assign log_wr_valid  = s_q.wr_v;
    assign log_wr_id     = s_q.wr_id;
    assign log_rd_ready  = rd_ready;
    assign replay_bad_id = s_q.err;

endmodule

// File: rtl/coa_checker.sv
module coa_checker #(
    parameter int N_CORES = 6,
    parameter int ID_W    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode,
    input logic [N_CORES-1:0] req,
    input logic [N_CORES-1:0] gnt,
    input logic               log_wr_valid,
    input logic [ID_W-1:0]    log_wr_id,
    input logic               log_rd_ready,
    input logic               replay_bad_id
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_gnt_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_gnt_to_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) |-> ((gnt & ~$past(req)) == '0));

    p_gnt_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) |-> ((gnt & $past(gnt)) == '0));

    p_log_matches_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        log_wr_valid |-> |(gnt & (N_CORES'(1) << log_wr_id)));

    p_log_only_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && log_wr_valid) |-> ($past(mode) == 2'b00));

    p_ready_only_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        log_rd_ready |-> (mode == 2'b10));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(replay_bad_id)) |-> replay_bad_id);

    p_quiet_on_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(mode) != $past(mode, 2)) |-> (gnt == '0));

endmodule

bind commit_order_arbiter coa_checker #(.N_CORES(N_CORES), .ID_W(ID_W)) u_coa_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .req           (req),
    .gnt           (gnt),
    .log_wr_valid  (log_wr_valid),
    .log_wr_id     (log_wr_id),
    .log_rd_ready  (log_rd_ready),
    .replay_bad_id (replay_bad_id)
);

// File: tb/tb_commit_order_arbiter.sv
`timescale 1ns/1ps
module tb_commit_order_arbiter;
    localparam int N    = 6;
    localparam int IDW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     mode = 2'b00;
    logic [N-1:0]   req = '0;
    logic [N-1:0]   gnt;
    logic           log_wr_valid;
    logic [IDW-1:0] log_wr_id;
    logic           log_rd_valid = 1'b0;
    logic [IDW-1:0] log_rd_id = '0;
    logic           log_rd_ready;
    logic           replay_bad_id;

    always #2.5 clk = ~clk;

    commit_order_arbiter #(.N_CORES(N)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .req(req), .gnt(gnt),
        .log_wr_valid(log_wr_valid), .log_wr_id(log_wr_id),
        .log_rd_valid(log_rd_valid), .log_rd_id(log_rd_id),
        .log_rd_ready(log_rd_ready), .replay_bad_id(replay_bad_id)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference state
    int m_mode, m_turn, m_hold, m_prev, m_err;
    int log_q[$];
    int grants_seen;

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_turn = 0; m_hold = -1; m_prev = -1; m_err = 0;
    endtask

    task automatic cyc();
        int  win;
        int  e_wv;
        bit  e_ready;
        bit  popped;
        string tag;
        win    = -1;
        popped = 0;
        log_rd_valid = (log_q.size() > 0);
        log_rd_id    = log_rd_valid ? IDW'(log_q[0]) : '0;
        #1;
        e_ready = (m_mode == 2) && (int'(mode) == 2) && (m_hold < 0);
        check(log_rd_ready == e_ready, "R5 ready", int'(log_rd_ready), int'(e_ready));
        tag = "R2";
        if (int'(mode) != m_mode) begin
            m_mode = int'(mode); m_turn = 0; m_hold = -1; tag = "R9";
        end else if (m_mode == 0) begin
            for (int k = 0; k < N; k++) begin
                int idx;
                idx = (m_turn + k) % N;
                if (win < 0 && req[idx] && idx != m_prev) win = idx;
            end
            if (win >= 0) m_turn = (win + 1) % N;
        end else if (m_mode == 1 || m_mode == 3) begin
            tag = "R4";
            if (req[m_turn] && m_turn != m_prev) begin
                win = m_turn; m_turn = (m_turn + 1) % N;
            end
        end else begin
            tag = (m_hold < 0 && log_q.size() == 0) ? "R7" : "R6";
            if (m_hold >= 0 && req[m_hold] && m_hold != m_prev) begin
                win = m_hold; m_hold = -1;
            end else if (e_ready && log_q.size() > 0) begin
                popped = 1;
                if (log_q[0] >= N) m_err = 1;
                else               m_hold = log_q[0];
            end
        end
        e_wv   = (m_mode == 0 && win >= 0 && tag != "R9") ? 1 : 0;
        m_prev = win;
        @(posedge clk);
        @(negedge clk);
        if (popped) void'(log_q.pop_front());
        if (win >= 0) grants_seen++;
        check($countones(gnt) <= 1, "R1 onehot", $countones(gnt), 1);
        check(gnt == ((win >= 0) ? (N'(1) << win) : N'(0)), tag,
              int'(gnt), (win >= 0) ? (1 << win) : 0);
        check(int'(log_wr_valid) == e_wv, "R3 wr_valid", int'(log_wr_valid), e_wv);
        if (e_wv == 1)
            check(int'(log_wr_id) == win, "R3 wr_id", int'(log_wr_id), win);
        check(int'(replay_bad_id) == m_err, "R8 err", int'(replay_bad_id), m_err);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mode  = 2'b00;
        req   = '0;
        repeat (3) @(negedge clk);
        check(gnt == '0, "R10 gnt", int'(gnt), 0);
        check(log_wr_valid == 1'b0, "R10 wr", int'(log_wr_valid), 0);
        check(log_rd_ready == 1'b0, "R10 ready", int'(log_rd_ready), 0);
        check(replay_bad_id == 1'b0, "R10 err", int'(replay_bad_id), 0);
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        log_q = {};
        grants_seen = 0;
        do_reset();

        // R2, R3: free mode, several request patterns
        req = '1;            run(12);
        req = 6'b001000;     run(6);
        req = 6'b100101;     run(8);

        // R4: turn mode; a lone requester whose turn has not come waits
        mode = 2'b01; req = 6'b000100;
        grants_seen = 0;
        run(6);
        check(grants_seen == 0, "R4 lone stall", grants_seen, 0);
        req = '1;            run(10);
        req = 6'b000110;     run(8);

        // R6, R8: log replay with a bad ID in the middle
        mode = 2'b10; req = '1;
        log_q = {2, 0, 5, 1, 7, 3};
        run(20);

        // R7: empty log gives no grant
        grants_seen = 0;
        run(5);
        check(grants_seen == 0, "R7 empty log", grants_seen, 0);

        // R9: held entry dropped by a mode switch
        req = '0; log_q = {4};
        run(3);
        mode = 2'b11; req = '1; run(8);
        mode = 2'b10; log_q = {1};
        run(6);
        req = 6'b010000; run(3);

        // R8 flag clears only by reset
        check(replay_bad_id == 1'b1, "R8 sticky", int'(replay_bad_id), 1);
        do_reset();
        run(2);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule